// File: doc/BRIEF.md
# Interprocessor and Timer Interrupt Unit

This unit keeps two pending flags per processor, one for interprocessor interrupts and one for interval-timer interrupts, for up to four processors. Software reaches it through one control word. On a write, three 4-bit processor masks in that word request interprocessor interrupts, drop them, and drop timer interrupts. A periodic tick from an external timer raises the timer flag of every present processor. Each interprocessor flag drives that processor's priority-level-3 interrupt output, and each timer flag drives its priority-level-2 output.

Each flag is a two-state machine, `SLOT_IDLE` and `SLOT_PEND`. The `REQ_SET` transition goes from `SLOT_IDLE` to `SLOT_PEND` when a set arrives. The `CLR_DROP` transition goes from `SLOT_PEND` back to `SLOT_IDLE` when a clear arrives. A timer slot takes `CLR_DROP` only when no tick comes in the same cycle. In every other case the slot holds its state. A set that reaches a pending interprocessor slot changes nothing and is reported as a redundant request. A clear that reaches an idle interprocessor slot changes nothing and is reported as a redundant clear.

A read returns the accessing processor's identifier and both groups of pending flags. The read is combinational.

Top module: `ipi_timer_intc`

## Requirements
- R1: For every present processor whose bit is set in write bits [15:12] (bit 12 is processor 0), the interprocessor flag is set at the clock edge that takes the write, unless that processor's bit in [11:8] is also set while it is pending (see R7). Output `ipi_irq[i]` (level 3) equals processor i's interprocessor flag.
- R2: For every present processor whose bit is set in write bits [11:8] (bit 8 is processor 0) and whose interprocessor flag is pending, the flag is cleared at the clock edge that takes the write, unless that processor's bit in [15:12] is also set while it is idle (see R7).
- R3: For every present processor whose bit is set in write bits [7:4] (bit 4 is processor 0), the timer flag is cleared at the clock edge that takes the write, unless a tick comes in the same cycle. Clearing an idle timer flag has no effect and raises no report. Output `tmr_irq[i]` (level 2) equals processor i's timer flag.
- R4: A request aimed at a present processor that already has an interprocessor interrupt pending leaves that flag set. For such a write, `redundant_req` is high for exactly the one cycle after the write edge.
- R5: A clear aimed at a present processor that has no interprocessor interrupt pending leaves that flag clear. For such a write, `redundant_clr` is high for exactly the one cycle after the write edge.
- R6: A cycle with `tick` high sets the timer flag of every present processor. If a timer clear for a processor comes in the same cycle as a tick, the tick wins and the flag ends up set.
- R7: When one write both requests and clears the same present processor, the state before the write decides the result. A pending flag is cleared, and the request is reported as redundant. An idle flag is set, and the clear is reported as redundant.
- R8: Mask bits and ticks for processors at or above `NUM_CPU` are ignored. The flags of those processors stay at 0, and those mask bits never raise a redundancy report.
- R9: While `rd_en` is high, `rdata` carries `req_cpu` in bits [1:0], the timer flags in [7:4] and the interprocessor flags in [11:8], all in the same cycle. Every other bit reads 0. While `rd_en` is low, `rdata` is all zero.
- R10: An active-low reset clears every pending flag and both redundancy outputs, which deasserts every interrupt output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wdata | input | DATA_W | Control word write data |
| rd_en | input | 1 | Control word read strobe |
| req_cpu | input | 2 | Identifier of the accessing processor |
| tick | input | 1 | Periodic timer tick, one cycle per period |
| rdata | output | DATA_W | Read data |
| ipi_irq | output | 4 | Level-3 interprocessor interrupt per processor |
| tmr_irq | output | 4 | Level-2 timer interrupt per processor |
| redundant_req | output | 1 | A request hit an already pending processor |
| redundant_clr | output | 1 | A clear hit a processor with nothing pending |

## Verification
The vector walk writes masks that hit fresh processors, already pending ones and idle ones. This tells a real set or clear apart from a redundant one, and a correct redundancy report from a missing or misplaced one. Writes that request and clear the same processor, starting from a pending flag and from an idle flag, show whether the state before the write decides the result. A tick sent together with a timer clear shows which of the two wins. A second instance built for two processors gets full masks and ticks, which shows that absent processors stay idle and raise no report. Reads with different identifiers and with the strobe low check each field position of the read word.

// File: rtl/ipitmr_pkg.sv
package ipitmr_pkg;
    localparam int MAX_CPU    = 4;
    localparam int CPU_ID_W   = $clog2(MAX_CPU);
    // Write word field positions
    localparam int WR_REQ_LSB  = 12;
    localparam int WR_CLR_LSB  = 8;
    localparam int WR_TCLR_LSB = 4;
    // Read word field positions
    localparam int RD_ID_LSB   = 0;
    localparam int RD_TMR_LSB  = 4;
    localparam int RD_IPI_LSB  = 8;

    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_PEND = 1'b1
    } slot_state_e;

    function automatic logic [MAX_CPU-1:0] present_mask(input int n);
        logic [MAX_CPU-1:0] m;
        for (int i = 0; i < MAX_CPU; i++) begin
            m[i] = (i < n);
        end
        return m;
    endfunction
endpackage

// File: rtl/ipitmr_decode.sv
module ipitmr_decode
    import ipitmr_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int DATA_W  = 64
) (
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [MAX_CPU-1:0] req_m,
    output logic [MAX_CPU-1:0] clr_m,
    output logic [MAX_CPU-1:0] tclr_m
);
    localparam logic [MAX_CPU-1:0] PRESENT = present_mask(NUM_CPU);

    logic unused_bits;
    assign unused_bits = ^{wdata[DATA_W-1:WR_REQ_LSB+MAX_CPU], wdata[WR_TCLR_LSB-1:0]};

    always_comb begin
        req_m  = '0;
        clr_m  = '0;
        tclr_m = '0;
        if (wr_en) begin
            req_m  = wdata[WR_REQ_LSB  +: MAX_CPU] & PRESENT;
            clr_m  = wdata[WR_CLR_LSB  +: MAX_CPU] & PRESENT;
            tclr_m = wdata[WR_TCLR_LSB +: MAX_CPU] & PRESENT;
        end
    end
endmodule

// File: rtl/ipitmr_slot.sv
module ipitmr_slot
    import ipitmr_pkg::*;
#(
    parameter bit SET_WINS = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o,
    output logic dup_set_o,
    output logic dup_clr_o
);
    slot_state_e cur_q, nxt;

    always_comb begin
        nxt = cur_q;
        unique case (cur_q)
            SLOT_IDLE: if (set_i) nxt = SLOT_PEND;                         // REQ_SET
            SLOT_PEND: if (clr_i && !(SET_WINS && set_i)) nxt = SLOT_IDLE; // CLR_DROP
            default:   nxt = SLOT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= SLOT_IDLE;
        else        cur_q <= nxt;
    end

    always_comb begin
        pend_o    = 1'b0;
        dup_set_o = 1'b0;
        dup_clr_o = 1'b0;
        unique case (cur_q)
            SLOT_IDLE: dup_clr_o = clr_i;
            SLOT_PEND: begin
                pend_o    = 1'b1;
                dup_set_o = set_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ipitmr_readback.sv
module ipitmr_readback
    import ipitmr_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                rd_en,
    input  logic [CPU_ID_W-1:0] req_cpu,
    input  logic [MAX_CPU-1:0]  ipi_pend,
    input  logic [MAX_CPU-1:0]  tmr_pend,
    output logic [DATA_W-1:0]   rdata
);
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            rdata[RD_ID_LSB  +: CPU_ID_W] = req_cpu;
            rdata[RD_TMR_LSB +: MAX_CPU]  = tmr_pend;
            rdata[RD_IPI_LSB +: MAX_CPU]  = ipi_pend;
        end
    end
endmodule

// File: rtl/ipi_timer_intc.sv
module ipi_timer_intc
    import ipitmr_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int DATA_W  = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                rd_en,
    input  logic [CPU_ID_W-1:0] req_cpu,
    input  logic                tick,
    output logic [DATA_W-1:0]   rdata,
    output logic [MAX_CPU-1:0]  ipi_irq,
    output logic [MAX_CPU-1:0]  tmr_irq,
    output logic                redundant_req,
    output logic                redundant_clr
);
    localparam logic [MAX_CPU-1:0] PRESENT = present_mask(NUM_CPU);

    logic [MAX_CPU-1:0] req_m, clr_m, tclr_m;
    logic [MAX_CPU-1:0] ipi_dup_set, ipi_dup_clr;
    logic [MAX_CPU-1:0] tmr_dup_set_unused, tmr_dup_clr_unused;

    ipitmr_decode #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) decode_i (
        .wr_en (wr_en),
        .wdata (wdata),
        .req_m (req_m),
        .clr_m (clr_m),
        .tclr_m(tclr_m)
    );

    for (genvar i = 0; i < MAX_CPU; i++) begin : g_cpu
        ipitmr_slot #(.SET_WINS(1'b0)) ipi_slot_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (req_m[i]),
            .clr_i    (clr_m[i]),
            .pend_o   (ipi_irq[i]),
            .dup_set_o(ipi_dup_set[i]),
            .dup_clr_o(ipi_dup_clr[i])
        );
        ipitmr_slot #(.SET_WINS(1'b1)) tmr_slot_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (tick & PRESENT[i]),
            .clr_i    (tclr_m[i]),
            .pend_o   (tmr_irq[i]),
            .dup_set_o(tmr_dup_set_unused[i]),
            .dup_clr_o(tmr_dup_clr_unused[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            redundant_req <= 1'b0;
            redundant_clr <= 1'b0;
        end else begin
            redundant_req <= |ipi_dup_set;
            redundant_clr <= |ipi_dup_clr;
        end
    end

    ipitmr_readback #(.DATA_W(DATA_W)) readback_i (
        .rd_en   (rd_en),
        .req_cpu (req_cpu),
        .ipi_pend(ipi_irq),
        .tmr_pend(tmr_irq),
        .rdata   (rdata)
    );
endmodule

// File: rtl/ipitmr_chk.sv
module ipitmr_chk
    import ipitmr_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int DATA_W  = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [DATA_W-1:0]  wdata,
    input logic               tick,
    input logic [MAX_CPU-1:0] ipi_irq,
    input logic [MAX_CPU-1:0] tmr_irq,
    input logic               redundant_req
);
    localparam logic [MAX_CPU-1:0] PM = present_mask(NUM_CPU);

    logic [MAX_CPU-1:0] w_req, w_clr, w_tclr;
    assign w_req  = wdata[WR_REQ_LSB  +: MAX_CPU] & PM;
    assign w_clr  = wdata[WR_CLR_LSB  +: MAX_CPU] & PM;
    assign w_tclr = wdata[WR_TCLR_LSB +: MAX_CPU] & PM;

    // R1
    req_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((ipi_irq & $past(w_req & ~w_clr)) == $past(w_req & ~w_clr)));
    // R2
    clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((ipi_irq & $past(w_clr & ~w_req)) == '0));
    // R3
    tclr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !tick) |=> ((tmr_irq & $past(w_tclr)) == '0));
    // R4
    dup_req_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ((w_req & ipi_irq) != '0)) |=> redundant_req);
    // R6
    tick_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> ((tmr_irq & PM) == PM));
    // R7
    both_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (((ipi_irq ^ $past(ipi_irq)) & $past(w_req & w_clr)) == $past(w_req & w_clr)));
    // R8
    absent_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ipi_irq | tmr_irq) & ~PM) == '0);
endmodule

bind ipi_timer_intc ipitmr_chk #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wdata        (wdata),
    .tick         (tick),
    .ipi_irq      (ipi_irq),
    .tmr_irq      (tmr_irq),
    .redundant_req(redundant_req)
);

// File: tb/ipi_timer_intc_tb_top.sv
`timescale 1ns/1ps
module ipi_timer_intc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  req_cpu = '0;
    logic        tick = 1'b0;
    logic [63:0] rdata, rdata_m;
    logic [3:0]  ipi_irq, tmr_irq, ipi_m, tmr_m;
    logic        rr, rc, rr_m, rc_m;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    ipi_timer_intc #(.NUM_CPU(4), .DATA_W(64)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
        .req_cpu(req_cpu), .tick(tick), .rdata(rdata), .ipi_irq(ipi_irq),
        .tmr_irq(tmr_irq), .redundant_req(rr), .redundant_clr(rc));

    ipi_timer_intc #(.NUM_CPU(2), .DATA_W(64)) dut_m (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
        .req_cpu(req_cpu), .tick(tick), .rdata(rdata_m), .ipi_irq(ipi_m),
        .tmr_irq(tmr_m), .redundant_req(rr_m), .redundant_clr(rc_m));

    // {req[4], clr[4], tclr[4], tick, exp_ipi[4], exp_tmr[4], exp_rr, exp_rc}
    localparam int NV = 12;
    localparam logic [22:0] VEC [NV] = '{
        {4'b0011, 4'b0000, 4'b0000, 1'b0, 4'b0011, 4'b0000, 1'b0, 1'b0},
        {4'b0110, 4'b0000, 4'b0000, 1'b0, 4'b0111, 4'b0000, 1'b1, 1'b0},
        {4'b0000, 4'b0001, 4'b0000, 1'b0, 4'b0110, 4'b0000, 1'b0, 1'b0},
        {4'b0000, 4'b1001, 4'b0000, 1'b0, 4'b0110, 4'b0000, 1'b0, 1'b1},
        {4'b0000, 4'b0000, 4'b0000, 1'b1, 4'b0110, 4'b1111, 1'b0, 1'b0},
        {4'b0000, 4'b0000, 4'b0101, 1'b0, 4'b0110, 4'b1010, 1'b0, 1'b0},
        {4'b0000, 4'b0000, 4'b1000, 1'b1, 4'b0110, 4'b1111, 1'b0, 1'b0},
        {4'b1000, 4'b0100, 4'b0000, 1'b0, 4'b1010, 4'b1111, 1'b0, 1'b0},
        {4'b0010, 4'b0010, 4'b0000, 1'b0, 4'b1000, 4'b1111, 1'b1, 1'b0},
        {4'b0001, 4'b0001, 4'b0000, 1'b0, 4'b1001, 4'b1111, 1'b0, 1'b1},
        {4'b0000, 4'b0000, 4'b1111, 1'b0, 4'b1001, 4'b0000, 1'b0, 1'b0},
        {4'b0000, 4'b0000, 4'b0001, 1'b0, 4'b1001, 4'b0000, 1'b0, 1'b0}
    };

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Drive one cycle at a negedge; returns at the next negedge with inputs idle.
    task automatic step(input logic [3:0] rq, input logic [3:0] cl,
                        input logic [3:0] tc, input logic tk);
        wr_en = (rq | cl | tc) != 4'b0000;
        wdata = 64'({rq, cl, tc, 4'b0000});
        tick  = tk;
        @(negedge clk);
        wr_en = 1'b0;
        wdata = '0;
        tick  = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 ipi after reset", 64'(ipi_irq), 64'h0);
        chk("R10 tmr after reset", 64'(tmr_irq), 64'h0);
        chk("R10 redundancy after reset", 64'({rr, rc}), 64'h0);
        rd_en = 1'b1; req_cpu = 2'd2; #1;
        chk("R9 read after reset", rdata, 64'h2);
        rd_en = 1'b0; req_cpu = 2'd0;

        for (int v = 0; v < NV; v++) begin
            logic [22:0] e;
            e = VEC[v];
            step(e[22:19], e[18:15], e[14:11], e[10]);
            chk($sformatf("R1 R2 R7 ipi vec %0d", v), 64'(ipi_irq), 64'(e[9:6]));
            chk($sformatf("R3 R6 tmr vec %0d", v), 64'(tmr_irq), 64'(e[5:2]));
            chk($sformatf("R4 R7 redundant_req vec %0d", v), 64'(rr), 64'(e[1]));
            chk($sformatf("R5 R7 redundant_clr vec %0d", v), 64'(rc), 64'(e[0]));
        end

        // R4 pulse length: state ipi=1001
        step(4'b1000, 4'b0000, 4'b0000, 1'b0);
        chk("R4 redundant request pulse", 64'(rr), 64'h1);
        chk("R4 state unchanged", 64'(ipi_irq), 64'h9);
        @(negedge clk);
        chk("R4 pulse drops after one cycle", 64'(rr), 64'h0);
        // R5 pulse length
        step(4'b0000, 4'b0100, 4'b0000, 1'b0);
        chk("R5 redundant clear pulse", 64'(rc), 64'h1);
        @(negedge clk);
        chk("R5 pulse drops after one cycle", 64'(rc), 64'h0);

        // R9 read format
        step(4'b0000, 4'b0000, 4'b0000, 1'b1);
        rd_en = 1'b1; req_cpu = 2'd3; #1;
        chk("R9 read id 3", rdata, 64'h9F3);
        req_cpu = 2'd1; #1;
        chk("R9 read id 1", rdata, 64'h9F1);
        rd_en = 1'b0; #1;
        chk("R9 read strobe low", rdata, 64'h0);

        // R10 reset from a busy state, then R8 on the two-processor instance
        do_reset();
        chk("R10 ipi cleared by reset", 64'(ipi_irq), 64'h0);
        chk("R10 tmr cleared by reset", 64'(tmr_irq), 64'h0);
        step(4'b1111, 4'b0000, 4'b0000, 1'b0);
        chk("R8 absent requests ignored", 64'(ipi_m), 64'h3);
        step(4'b1100, 4'b0000, 4'b0000, 1'b0);
        chk("R8 absent request not redundant", 64'(rr_m), 64'h0);
        chk("R8 absent request state", 64'(ipi_m), 64'h3);
        step(4'b0000, 4'b1100, 4'b0000, 1'b0);
        chk("R8 absent clear not redundant", 64'(rc_m), 64'h0);
        step(4'b0000, 4'b0000, 4'b0000, 1'b1);
        chk("R8 tick only present", 64'(tmr_m), 64'h3);
        rd_en = 1'b1; req_cpu = 2'd1; #1;
        chk("R8 R9 read two-processor", rdata_m, 64'h331);
        rd_en = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule